// File: doc/BRIEF.md
# RTC Interrupt Flag Combiner

This block collects the event sources of a real-time clock into a single active-low interrupt line. There are five sources: the alarm, a bank of timestamp inputs, battery switch-over, battery-low and the watchdog. Each source keeps a status flag and has an enable bit. The interrupt is asserted while at least one source has both its flag and its enable set. The output is a registered level that follows the flags. It never produces a pulse.

The sources do not all clear the same way. The host clears the alarm, timestamp and switch-over flags by writing 0 to them through a simple register strobe. The battery-low flag is a synchronised copy of the low-battery condition, so it clears only when that condition goes away. The watchdog flag ignores host writes and clears only on a dedicated service strobe. Timekeeping, alarm matching, battery sensing and the serial bus are outside the block. They appear only as event inputs, a condition input and a write strobe with an address.

Top module: `rtc_irq_combiner`

## Requirements
- R1: After reset, every flag and every enable is 0, `irq_n` is 1, and every register reads 0.
- R2: The alarm, each timestamp, switch-over and watchdog flag is set in the clock edge where its event input is first seen high after being low. An input held high does not set the flag again after it has been cleared.
- R3: A host write to address 0 with bit 4 at 0 clears the alarm flag. A write with bit 4+1+i at 0 clears timestamp flag i. A write to address 1 with bit 4 at 0 clears the switch-over flag. Writing 1 to any of these bits leaves the flag unchanged.
- R4: When a rising event and a clearing action (a host write or a watchdog service) fall in the same cycle, the flag ends up set.
- R5: `irq_n` is 0 in the cycle after the one in which any flag and its own enable are both 1, and 1 in the cycle after the one in which no such pair exists.
- R6: Each timestamp input has its own flag. The timestamp sources raise the interrupt if any of their flags is set, and each flag clears independently.
- R7: The battery-low flag equals the battery-low condition input delayed by SYNC_STAGES clock edges (default 2). Host writes never change it.
- R8: Host writes never change the watchdog flag. A `wdog_service` pulse with no simultaneous rising watchdog event clears it.
- R9: Writing 0 to a source's enable removes that source from the interrupt without changing its flag.
- R10: Register map. Address 0: bit 0 alarm enable, bit 1 timestamp enable, bit 4 alarm flag, bits 5 to 4+NUM_TS timestamp flags. Address 1: bit 0 switch-over enable, bit 1 battery-low enable, bit 4 switch-over flag, bit 5 battery-low flag (read-only). Address 2: bit 0 watchdog enable, bit 4 watchdog flag (read-only). Each write loads the enable bits of the addressed register from the written data. Unused bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_evt | input | 1 | Alarm match event |
| ts_evt | input | NUM_TS | Timestamp events, one per input |
| swo_evt | input | 1 | Battery switch-over event |
| batlow_cond | input | 1 | Battery-low condition level, asynchronous |
| wdog_evt | input | 1 | Watchdog expiry event |
| wdog_service | input | 1 | Watchdog service strobe, clears the watchdog flag |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
Two collisions are the hardest cases to reach from the ports. The first is a host clear that lands in exactly the same cycle as a fresh rising event. The second is a service strobe that coincides with a new watchdog expiry. In both, a wrong priority silently loses the event. The stimulus forces each collision directly: it lowers the event line one cycle earlier, then raises it in the same cycle as the clearing write or the service strobe. A long random phase adds more of these overlaps while the behavioural model is compared on every clock. A second awkward case is an event line held high across a clear. The bench keeps the line high and checks that the flag stays clear.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CTRL_A = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CTRL_B = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_WDOG   = 2'd2;

    // bit positions shared by all registers
    localparam int BIT_EN0   = 0;
    localparam int BIT_EN1   = 1;
    localparam int BIT_FLAG0 = 4;
    localparam int BIT_FLAG1 = 5;

    typedef enum logic [2:0] {
        SRC_ALARM  = 3'd0,
        SRC_TS     = 3'd1,
        SRC_SWO    = 3'd2,
        SRC_BATLOW = 3'd3,
        SRC_WDOG   = 3'd4
    } irq_src_e;

    typedef struct packed {
        logic alarm;
        logic ts;
        logic swo;
        logic batlow;
        logic wdog;
    } irq_vec_t;

    function automatic logic any_pending(input irq_vec_t flags, input irq_vec_t en);
        irq_vec_t both;
        both = flags & en;
        return |both;
    endfunction

endpackage

// File: rtl/irq_edge_flag.sv
module irq_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    logic evt_prev;
    logic rise;

    // the previous value is tracked through reset so no spurious edge appears
    always_ff @(posedge clk) begin
        evt_prev <= evt;
    end

    assign rise = evt & ~evt_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (rise) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import rtc_irq_pkg::*;
#(
    parameter int NUM_TS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              alarm_flag,
    input  logic [NUM_TS-1:0] ts_flag,
    input  logic              swo_flag,
    input  logic              batlow_flag,
    input  logic              wdog_flag,
    output irq_vec_t          en,
    output logic              alarm_clr,
    output logic [NUM_TS-1:0] ts_clr,
    output logic              swo_clr
);
    localparam int TS_BASE = BIT_FLAG0 + 1;

    logic wr_a;
    logic wr_b;
    logic wr_w;

    assign wr_a = reg_wr && (reg_addr == ADDR_CTRL_A);
    assign wr_b = reg_wr && (reg_addr == ADDR_CTRL_B);
    assign wr_w = reg_wr && (reg_addr == ADDR_WDOG);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else begin
            if (wr_a) begin
                en.alarm <= reg_wdata[BIT_EN0];
                en.ts    <= reg_wdata[BIT_EN1];
            end
            if (wr_b) begin
                en.swo    <= reg_wdata[BIT_EN0];
                en.batlow <= reg_wdata[BIT_EN1];
            end
            if (wr_w) begin
                en.wdog <= reg_wdata[BIT_EN0];
            end
        end
    end

    // clearing is by writing 0 to a flag bit
    assign alarm_clr = wr_a && !reg_wdata[BIT_FLAG0];
    assign swo_clr   = wr_b && !reg_wdata[BIT_FLAG0];

    for (genvar i = 0; i < NUM_TS; i++) begin : g_ts_clr
        assign ts_clr[i] = wr_a && !reg_wdata[TS_BASE+i];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL_A: begin
                reg_rdata[BIT_EN0]   = en.alarm;
                reg_rdata[BIT_EN1]   = en.ts;
                reg_rdata[BIT_FLAG0] = alarm_flag;
                for (int i = 0; i < NUM_TS; i++) begin
                    reg_rdata[TS_BASE+i] = ts_flag[i];
                end
            end
            ADDR_CTRL_B: begin
                reg_rdata[BIT_EN0]   = en.swo;
                reg_rdata[BIT_EN1]   = en.batlow;
                reg_rdata[BIT_FLAG0] = swo_flag;
                reg_rdata[BIT_FLAG1] = batlow_flag;
            end
            ADDR_WDOG: begin
                reg_rdata[BIT_EN0]   = en.wdog;
                reg_rdata[BIT_FLAG0] = wdog_flag;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_irq_combiner.sv
module rtc_irq_combiner
    import rtc_irq_pkg::*;
#(
    parameter int NUM_TS      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              alarm_evt,
    input  logic [NUM_TS-1:0] ts_evt,
    input  logic              swo_evt,
    input  logic              batlow_cond,
    input  logic              wdog_evt,
    input  logic              wdog_service,
    output logic              irq_n
);
    logic              alarm_flag;
    logic [NUM_TS-1:0] ts_flag;
    logic              swo_flag;
    logic              batlow_flag;
    logic              wdog_flag;
    logic              alarm_clr;
    logic [NUM_TS-1:0] ts_clr;
    logic              swo_clr;
    irq_vec_t          en;
    irq_vec_t          flags;
    logic              any_active;
    logic              irq_n_q;

    irq_regfile #(.NUM_TS(NUM_TS)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .alarm_flag  (alarm_flag),
        .ts_flag     (ts_flag),
        .swo_flag    (swo_flag),
        .batlow_flag (batlow_flag),
        .wdog_flag   (wdog_flag),
        .en          (en),
        .alarm_clr   (alarm_clr),
        .ts_clr      (ts_clr),
        .swo_clr     (swo_clr)
    );

    irq_edge_flag i_alarm (
        .clk (clk), .rst (rst), .evt (alarm_evt), .clr (alarm_clr), .flag (alarm_flag)
    );

    for (genvar i = 0; i < NUM_TS; i++) begin : g_ts
        irq_edge_flag i_ts (
            .clk (clk), .rst (rst), .evt (ts_evt[i]), .clr (ts_clr[i]), .flag (ts_flag[i])
        );
    end

    irq_edge_flag i_swo (
        .clk (clk), .rst (rst), .evt (swo_evt), .clr (swo_clr), .flag (swo_flag)
    );

    irq_edge_flag i_wdog (
        .clk (clk), .rst (rst), .evt (wdog_evt), .clr (wdog_service), .flag (wdog_flag)
    );

    irq_level_sync #(.STAGES(SYNC_STAGES)) i_batlow (
        .clk (clk), .rst (rst), .din (batlow_cond), .dout (batlow_flag)
    );

    always_comb begin
        flags        = '0;
        flags.alarm  = alarm_flag;
        flags.ts     = |ts_flag;
        flags.swo    = swo_flag;
        flags.batlow = batlow_flag;
        flags.wdog   = wdog_flag;
    end

    assign any_active = any_pending(flags, en);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~any_active;
        end
    end

    assign irq_n = irq_n_q;
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       alarm_evt,
    input logic       wdog_evt,
    input logic       wdog_service,
    input logic       alarm_flag,
    input logic       wdog_flag,
    input logic       alarm_en,
    input logic       irq_n
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_n);

    // R5
    alarm_drives_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && alarm_en) |=> !irq_n);

    // R3
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && reg_wr && reg_addr == 2'd0 && reg_wdata[4]) |=> alarm_flag);

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_evt && !$past(alarm_evt) && reg_wr && reg_addr == 2'd0 && !reg_wdata[4])
        |=> alarm_flag);

    // R8
    wdog_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wdog_flag && !wdog_service && reg_wr && reg_addr == 2'd2) |=> wdog_flag);

    // R8
    wdog_service_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wdog_service && !(wdog_evt && !$past(wdog_evt))) |=> !wdog_flag);
endmodule

bind rtc_irq_combiner irq_combiner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .alarm_evt    (alarm_evt),
    .wdog_evt     (wdog_evt),
    .wdog_service (wdog_service),
    .alarm_flag   (alarm_flag),
    .wdog_flag    (wdog_flag),
    .alarm_en     (en.alarm),
    .irq_n        (irq_n)
);

// File: tb/test_rtc_irq_combiner.sv
`timescale 1ns/1ps
module test_rtc_irq_combiner;
    localparam int NUM_TS = 2;
    localparam int SYNC   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              alarm_evt = 1'b0;
    logic [NUM_TS-1:0] ts_evt = '0;
    logic              swo_evt = 1'b0;
    logic              batlow_cond = 1'b0;
    logic              wdog_evt = 1'b0;
    logic              wdog_service = 1'b0;
    logic              irq_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rtc_irq_combiner #(.NUM_TS(NUM_TS), .SYNC_STAGES(SYNC)) i_rtc_irq_combiner (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .alarm_evt (alarm_evt),
        .ts_evt (ts_evt), .swo_evt (swo_evt), .batlow_cond (batlow_cond),
        .wdog_evt (wdog_evt), .wdog_service (wdog_service), .irq_n (irq_n)
    );

    // behavioural reference model
    bit m_alarm, m_swo, m_bl, m_wd, m_irq = 1'b1;
    bit m_ts[NUM_TS];
    bit e_alarm, e_ts, e_swo, e_bl, e_wd;
    bit p_alarm, p_swo, p_wd;
    bit p_ts[NUM_TS];
    bit syncq[$];
    bit started = 1'b0;

    always @(posedge clk) begin
        bit any;
        bit wa, wb, ww;
        p_alarm <= alarm_evt;
        p_swo   <= swo_evt;
        p_wd    <= wdog_evt;
        for (int i = 0; i < NUM_TS; i++) p_ts[i] <= ts_evt[i];
        if (rst) begin
            m_alarm = 0; m_swo = 0; m_bl = 0; m_wd = 0; m_irq = 1;
            for (int i = 0; i < NUM_TS; i++) m_ts[i] = 0;
            e_alarm = 0; e_ts = 0; e_swo = 0; e_bl = 0; e_wd = 0;
            syncq.delete();
            for (int i = 0; i < SYNC - 1; i++) syncq.push_back(1'b0);
        end else begin
            any = (m_alarm && e_alarm) || (m_swo && e_swo) || (m_bl && e_bl) || (m_wd && e_wd);
            for (int i = 0; i < NUM_TS; i++) if (m_ts[i] && e_ts) any = 1;
            m_irq = !any;
            wa = reg_wr && reg_addr == 2'd0;
            wb = reg_wr && reg_addr == 2'd1;
            ww = reg_wr && reg_addr == 2'd2;
            if (alarm_evt && !p_alarm) m_alarm = 1; else if (wa && !reg_wdata[4]) m_alarm = 0;
            for (int i = 0; i < NUM_TS; i++)
                if (ts_evt[i] && !p_ts[i]) m_ts[i] = 1; else if (wa && !reg_wdata[5+i]) m_ts[i] = 0;
            if (swo_evt && !p_swo) m_swo = 1; else if (wb && !reg_wdata[4]) m_swo = 0;
            if (wdog_evt && !p_wd) m_wd = 1; else if (wdog_service) m_wd = 0;
            syncq.push_back(batlow_cond);
            m_bl = syncq.pop_front();
            if (wa) begin e_alarm = reg_wdata[0]; e_ts = reg_wdata[1]; end
            if (wb) begin e_swo = reg_wdata[0]; e_bl = reg_wdata[1]; end
            if (ww) e_wd = reg_wdata[0];
        end
        started = 1'b1;
    end

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        logic [7:0] r = '0;
        case (a)
            2'd0: begin
                r[0] = e_alarm; r[1] = e_ts; r[4] = m_alarm;
                for (int i = 0; i < NUM_TS; i++) r[5+i] = m_ts[i];
            end
            2'd1: begin r[0] = e_swo; r[1] = e_bl; r[4] = m_swo; r[5] = m_bl; end
            2'd2: begin r[0] = e_wd; r[4] = m_wd; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model (R5, R10)
    always @(negedge clk) begin
        if (started && !rst) begin
            check("R5 irq_n vs model", {31'd0, irq_n}, {31'd0, m_irq});
            check("R10 rdata vs model", {24'd0, reg_rdata}, {24'd0, model_rdata(reg_addr)});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 0;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        @(negedge clk);
        check(tag, {24'd0, reg_rdata}, {24'd0, exp});
        step(0);
        @(posedge clk); #1;
    endtask

    task automatic expect_irq(input string tag, input logic exp);
        @(negedge clk);
        check(tag, {31'd0, irq_n}, {31'd0, exp});
        @(posedge clk); #1;
    endtask

    initial begin
        #900000;
        fails++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(4);
        rst = 0;
        step(1);
        // R1 reset state
        expect_irq("R1 irq idle", 1'b1);
        expect_reg("R1 reg0", 2'd0, 8'h00);
        expect_reg("R1 reg1", 2'd1, 8'h00);
        expect_reg("R1 reg2", 2'd2, 8'h00);

        // R2 / R5 alarm sets and drives interrupt
        wr(2'd0, 8'h01);
        alarm_evt = 1; step(1);
        step(1);
        expect_reg("R2 alarm flag set", 2'd0, 8'h11);
        expect_irq("R5 irq low on alarm", 1'b0);

        // R2 held level does not re-set after clear, R3 clear by 0
        wr(2'd0, 8'h01);
        step(2);
        expect_reg("R2 held evt no reset", 2'd0, 8'h01);
        expect_irq("R3 irq released", 1'b1);

        // R3 writing 1 keeps flag
        alarm_evt = 0; step(1);
        alarm_evt = 1; step(2);
        wr(2'd0, 8'h71);
        step(1);
        expect_reg("R3 write one keeps", 2'd0, 8'h11);

        // R9 enable drop keeps flag, clears irq
        wr(2'd0, 8'h70);
        step(1);
        expect_reg("R9 flag kept", 2'd0, 8'h10);
        expect_irq("R9 irq off", 1'b1);

        // R4 set wins over simultaneous clear
        wr(2'd0, 8'h01);
        alarm_evt = 0; step(1);
        alarm_evt = 1;
        wr(2'd0, 8'h01);
        step(1);
        expect_reg("R4 set wins", 2'd0, 8'h11);
        alarm_evt = 0;
        wr(2'd0, 8'h00);

        // R6 timestamps
        wr(2'd0, 8'h02);
        ts_evt = 2'b10; step(1); ts_evt = 2'b00; step(2);
        expect_reg("R6 ts1 flag", 2'd0, 8'h42);
        expect_irq("R6 irq from ts1", 1'b0);
        ts_evt = 2'b01; step(1); ts_evt = 2'b00; step(1);
        wr(2'd0, 8'h22);
        step(1);
        expect_reg("R6 ts1 cleared ts0 kept", 2'd0, 8'h22);
        expect_irq("R6 irq still low", 1'b0);
        wr(2'd0, 8'h02);
        step(1);
        expect_irq("R6 irq high", 1'b1);

        // switch-over R2 R3
        wr(2'd1, 8'h01);
        swo_evt = 1; step(1); swo_evt = 0; step(2);
        expect_reg("R2 swo flag", 2'd1, 8'h11);
        expect_irq("R5 swo irq", 1'b0);
        wr(2'd1, 8'h01);
        step(1);
        expect_reg("R3 swo cleared", 2'd1, 8'h01);

        // R7 battery low
        wr(2'd1, 8'h02);
        batlow_cond = 1; step(1);
        expect_reg("R7 not yet", 2'd1, 8'h02);
        expect_reg("R7 synced", 2'd1, 8'h22);
        wr(2'd1, 8'h02);
        step(1);
        expect_reg("R7 write ignored", 2'd1, 8'h22);
        expect_irq("R7 irq low", 1'b0);
        batlow_cond = 0; step(3);
        expect_reg("R7 cleared by cond", 2'd1, 8'h02);
        expect_irq("R7 irq high", 1'b1);

        // R8 watchdog
        wr(2'd2, 8'h01);
        wdog_evt = 1; step(1); wdog_evt = 0; step(2);
        expect_reg("R8 wdog set", 2'd2, 8'h11);
        wr(2'd2, 8'h01);
        step(1);
        expect_reg("R8 write ignored", 2'd2, 8'h11);
        expect_irq("R8 irq low", 1'b0);
        wdog_service = 1; step(1); wdog_service = 0; step(1);
        expect_reg("R8 serviced", 2'd2, 8'h01);
        wdog_evt = 1; wdog_service = 1; step(1); wdog_service = 0; wdog_evt = 0; step(1);
        expect_reg("R4 R8 set beats service", 2'd2, 8'h11);

        // random phase, checked each cycle against the model
        for (int n = 0; n < 3000; n++) begin
            alarm_evt    = ($urandom % 8) == 0 ? ~alarm_evt : alarm_evt;
            ts_evt       = ts_evt ^ (($urandom % 8) == 0 ? 2'($urandom) : 2'b00);
            swo_evt      = ($urandom % 8) == 0 ? ~swo_evt : swo_evt;
            wdog_evt     = ($urandom % 10) == 0 ? ~wdog_evt : wdog_evt;
            batlow_cond  = ($urandom % 12) == 0 ? ~batlow_cond : batlow_cond;
            wdog_service = ($urandom % 9) == 0;
            reg_wr       = ($urandom % 4) == 0;
            reg_addr     = 2'($urandom);
            reg_wdata    = 8'($urandom);
            step(1);
        end
        reg_wr = 0; wdog_service = 0;
        step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule